// File: doc/BRIEF.md
# DDR2 Read Burst Sequencer

This block is the device side of a DDR2 read. It runs on the command clock and decodes the chip-select, row-strobe, column-strobe and write-enable pins. An ACTIVATE command opens a bank. A READ to an open bank schedules a data burst that appears a programmed number of cycles later. Each burst cycle carries two data words, one for the rising half of the clock and one for the falling half. The block also drives a strobe enable and a strobe level, which frame the burst with a preamble and a postamble, and an output enable for the data pins.

Read data comes from a small register file. The file is indexed by bank and by the low bits of the column, and reset loads it with a fixed pattern. Burst length, CAS latency and additive latency are set through a side port that addresses two mode registers. A READ issued exactly half a burst length after the previous one extends the stream with no gap. Address bit 10 of a READ selects auto-precharge, which closes the bank's row once the burst ends.

Top module: `ddr2_rd_seq`

## Requirements
- R1: A command is sampled on a rising clock edge. With cs_ni=0, ras_ni=1, cas_ni=0 and we_ni=1 it is a READ. With cs_ni=0, ras_ni=0, cas_ni=1 and we_ni=1 it is an ACTIVATE, which sets bank_open_o[ba_i]. Every other pin combination changes no output.
- R2: When mode_sel_i=0, a mode write sets the burst length from mode_data_i[2:0] (code 2 gives 4, code 3 gives 8) and the CAS latency from mode_data_i[6:4] (3 to 6). When mode_sel_i=1, it sets the additive latency from mode_data_i[5:3] (0 to 5). A code outside these ranges leaves that field unchanged. After reset the burst length is 4, the CAS latency is 3 and the additive latency is 0.
- R3: When a READ to an open bank is sampled on edge n, dq_oe_o is high in the cycles that follow edges n+RL through n+RL+BL/2-1, where RL is the additive latency plus the CAS latency.
- R4: In burst cycle j, dq_rise_o carries element 2j and dq_fall_o carries element 2j+1. Element e reads column (start & ~(BL-1)) | ((start+e) & (BL-1)), where start is addr_i[9:0]. The word at bank b and column c is the low 16 bits of (16*b + (c mod 16))*753 + 315. Both data outputs are zero whenever dq_oe_o is low.
- R5: In the cycle just before the first data cycle of a stream, dqs_en_o=1, dqs_o=0 and dq_oe_o=0.
- R6: In every data cycle, dqs_en_o=1 and dqs_o=1, meaning the strobe is high in the rising half.
- R7: In the cycle after the last data cycle of a stream, dqs_en_o=1, dqs_o=0 and dq_oe_o=0. When no other READ is pending, all strobe and enable outputs are low after that cycle.
- R8: A READ sampled exactly BL/2 edges after the previous READ continues the stream. dq_oe_o stays high for the combined length, with no preamble or postamble between the bursts.
- R9: When a READ has addr_i[10]=1, bank_open_o of its bank drops in the cycle after the burst's last data cycle. When addr_i[10]=0, the bank stays open.
- R10: A READ to a bank whose bank_open_o bit is low sets rd_err_o, which stays high until reset. Such a READ produces no data, strobe or enable activity.
- R11: While reset is active, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 3 | Bank address |
| addr_i | input | 11 | Bits 9:0 start column, bit 10 auto-precharge on READ |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_sel_i | input | 1 | 0 selects the main mode register, 1 the extended one |
| mode_data_i | input | 7 | Mode register write value |
| dq_rise_o | output | 16 | Data word for the rising half |
| dq_fall_o | output | 16 | Data word for the falling half |
| dq_oe_o | output | 1 | Data pin output enable |
| dqs_en_o | output | 1 | Strobe drive enable |
| dqs_o | output | 1 | Strobe level in the rising half; the complement is its inverse |
| bank_open_o | output | 8 | One bit per bank, set while a row is open |
| rd_err_o | output | 1 | Sticky flag for a READ to a closed bank |

## Verification
The assertions assume a well-behaved controller. READs come at least BL/2 edges apart, mode registers are written only while no burst is in flight, and no READ targets a bank on the edge its auto-precharge completes. Under those conditions, every rise of the output enable follows a preamble and every fall is followed by a postamble. The stimulus stays inside these limits by construction: each READ is followed by enough idle cycles, mode writes come only after the outputs have gone quiet, and chained READs use exactly the minimum spacing or one cycle more.

// File: rtl/ddr2_rd_pkg.sv
package ddr2_rd_pkg;
  localparam int unsigned BA_W  = 3;
  localparam int unsigned COL_W = 10;
  localparam int unsigned DW    = 16;

  typedef enum logic [1:0] {SLOT_IDLE, SLOT_PRE, SLOT_DATA, SLOT_POST} slot_kind_e;

  typedef struct packed {
    slot_kind_e        kind;
    logic              last;
    logic              ap;
    logic [BA_W-1:0]   bank;
    logic [COL_W-1:0]  col_r;
    logic [COL_W-1:0]  col_f;
  } slot_t;

  // sequential order, wrapping inside the burst-aligned block
  function automatic logic [COL_W-1:0] col_wrap(input logic [COL_W-1:0] start,
                                                input logic [3:0] inc, input logic bl8);
    logic [COL_W-1:0] m;
    m = bl8 ? COL_W'(7) : COL_W'(3);
    return (start & ~m) | ((start + COL_W'(inc)) & m);
  endfunction

  function automatic logic [DW-1:0] store_seed(input int unsigned idx);
    return DW'(idx * 753 + 315);
  endfunction
endpackage

// File: rtl/ddr2_rd_mode.sv
module ddr2_rd_mode #(
  parameter int unsigned CL_MIN = 3,
  parameter int unsigned CL_MAX = 6,
  parameter int unsigned AL_MAX = 5,
  parameter int unsigned LAT_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_we_i,
  input  logic             mode_sel_i,
  input  logic [6:0]       mode_data_i,
  output logic             bl8_o,
  output logic [LAT_W-1:0] rl_o
);
  logic [2:0] cl_q, al_q;
  logic       unused_bt;
  assign unused_bt = mode_data_i[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bl8_o <= 1'b0;
      cl_q  <= 3'(CL_MIN);
      al_q  <= 3'd0;
    end else if (mode_we_i) begin
      if (!mode_sel_i) begin
        if (mode_data_i[2:0] == 3'd2) bl8_o <= 1'b0;
        else if (mode_data_i[2:0] == 3'd3) bl8_o <= 1'b1;
        if (int'(mode_data_i[6:4]) >= CL_MIN && int'(mode_data_i[6:4]) <= CL_MAX)
          cl_q <= mode_data_i[6:4];
      end else if (int'(mode_data_i[5:3]) <= AL_MAX) begin
        al_q <= mode_data_i[5:3];
      end
    end
  end

  assign rl_o = LAT_W'(cl_q) + LAT_W'(al_q);
endmodule

// File: rtl/ddr2_rd_bank.sv
module ddr2_rd_bank import ddr2_rd_pkg::*; #(
  parameter int unsigned NB = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_ni,
  input  logic            ras_ni,
  input  logic            cas_ni,
  input  logic            we_ni,
  input  logic [BA_W-1:0] ba_i,
  input  logic            close_v_i,
  input  logic [BA_W-1:0] close_bank_i,
  output logic            rd_go_o,
  output logic [NB-1:0]   open_o,
  output logic            err_o
);
  logic is_rd, is_act;
  assign is_rd  = !cs_ni &&  ras_ni && !cas_ni && we_ni;
  assign is_act = !cs_ni && !ras_ni &&  cas_ni && we_ni;
  assign rd_go_o = is_rd && open_o[ba_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o <= '0;
      err_o  <= 1'b0;
    end else begin
      if (is_rd && !open_o[ba_i]) err_o <= 1'b1;
      for (int b = 0; b < NB; b++) begin
        if (close_v_i && close_bank_i == BA_W'(b)) open_o[b] <= 1'b0;
        if (is_act && ba_i == BA_W'(b)) open_o[b] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ddr2_rd_sched.sv
module ddr2_rd_sched import ddr2_rd_pkg::*; #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_go_i,
  input  logic [BA_W-1:0]  bank_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             ap_i,
  input  logic             bl8_i,
  input  logic [LAT_W-1:0] rl_i,
  output slot_t            head_o,
  output logic             close_v_o,
  output logic [BA_W-1:0]  close_bank_o
);
  slot_t q [DEPTH];
  slot_t d [DEPTH];

  always_comb begin
    int rl, half;
    rl   = int'(rl_i);
    half = bl8_i ? 4 : 2;
    for (int i = 0; i < DEPTH-1; i++) d[i] = q[i+1];
    d[DEPTH-1] = '0;
    if (rd_go_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        // data of an earlier burst wins over framing of a later one
        if (i == rl-1 && d[i].kind != SLOT_DATA) d[i].kind = SLOT_PRE;
        if (i >= rl && i < rl+half) begin
          d[i].kind  = SLOT_DATA;
          d[i].bank  = bank_i;
          d[i].ap    = ap_i;
          d[i].last  = (i == rl+half-1);
          d[i].col_r = col_wrap(col_i, 4'(2*(i-rl)), bl8_i);
          d[i].col_f = col_wrap(col_i, 4'(2*(i-rl)+1), bl8_i);
        end
        if (i == rl+half && d[i].kind == SLOT_IDLE) d[i].kind = SLOT_POST;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) q[i] <= d[i];
    end
  end

  assign head_o       = q[0];
  assign close_v_o    = q[0].kind == SLOT_DATA && q[0].last && q[0].ap;
  assign close_bank_o = q[0].bank;
endmodule

// File: rtl/ddr2_rd_store.sv
module ddr2_rd_store import ddr2_rd_pkg::*; #(
  parameter int unsigned NB  = 8,
  parameter int unsigned SCW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  slot_t         head_i,
  output logic [DW-1:0] dq_rise_o,
  output logic [DW-1:0] dq_fall_o,
  output logic          dq_oe_o,
  output logic          dqs_en_o,
  output logic          dqs_o
);
  localparam int unsigned WORDS = NB << SCW;
  localparam int unsigned IDX_W = BA_W + SCW;

  logic [DW-1:0]    mem [WORDS];
  logic [IDX_W-1:0] idx_r, idx_f;
  logic             is_data;
  logic             unused_hi;

  assign unused_hi = ^{head_i.last, head_i.ap,
                       head_i.col_r[COL_W-1:SCW], head_i.col_f[COL_W-1:SCW]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= store_seed(i);
    end
  end

  assign is_data   = head_i.kind == SLOT_DATA;
  assign idx_r     = {head_i.bank, head_i.col_r[SCW-1:0]};
  assign idx_f     = {head_i.bank, head_i.col_f[SCW-1:0]};
  assign dq_rise_o = is_data ? mem[idx_r] : '0;
  assign dq_fall_o = is_data ? mem[idx_f] : '0;
  assign dq_oe_o   = is_data;
  assign dqs_en_o  = head_i.kind != SLOT_IDLE;
  assign dqs_o     = is_data;
endmodule

// File: rtl/ddr2_rd_seq.sv
module ddr2_rd_seq import ddr2_rd_pkg::*; #(
  parameter int unsigned NB     = 8,
  parameter int unsigned SCW    = 4,
  parameter int unsigned CL_MIN = 3,
  parameter int unsigned CL_MAX = 6,
  parameter int unsigned AL_MAX = 5,
  parameter int unsigned BL_MAX = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          ras_ni,
  input  logic          cas_ni,
  input  logic          we_ni,
  input  logic [2:0]    ba_i,
  input  logic [10:0]   addr_i,
  input  logic          mode_we_i,
  input  logic          mode_sel_i,
  input  logic [6:0]    mode_data_i,
  output logic [15:0]   dq_rise_o,
  output logic [15:0]   dq_fall_o,
  output logic          dq_oe_o,
  output logic          dqs_en_o,
  output logic          dqs_o,
  output logic [7:0]    bank_open_o,
  output logic          rd_err_o
);
  localparam int unsigned DEPTH = AL_MAX + CL_MAX + BL_MAX/2 + 1;
  localparam int unsigned LAT_W = $clog2(AL_MAX + CL_MAX + 1);

  logic             bl8, rd_go, close_v;
  logic [LAT_W-1:0] rl;
  logic [BA_W-1:0]  close_bank;
  slot_t            head;

  ddr2_rd_mode #(.CL_MIN(CL_MIN), .CL_MAX(CL_MAX), .AL_MAX(AL_MAX), .LAT_W(LAT_W)) i_mode (
    .clk_i, .rst_ni, .mode_we_i, .mode_sel_i, .mode_data_i,
    .bl8_o(bl8), .rl_o(rl)
  );

  ddr2_rd_bank #(.NB(NB)) i_bank (
    .clk_i, .rst_ni, .cs_ni, .ras_ni, .cas_ni, .we_ni, .ba_i,
    .close_v_i(close_v), .close_bank_i(close_bank),
    .rd_go_o(rd_go), .open_o(bank_open_o), .err_o(rd_err_o)
  );

  ddr2_rd_sched #(.DEPTH(DEPTH), .LAT_W(LAT_W)) i_sched (
    .clk_i, .rst_ni, .rd_go_i(rd_go), .bank_i(ba_i), .col_i(addr_i[9:0]),
    .ap_i(addr_i[10]), .bl8_i(bl8), .rl_i(rl),
    .head_o(head), .close_v_o(close_v), .close_bank_o(close_bank)
  );

  ddr2_rd_store #(.NB(NB), .SCW(SCW)) i_store (
    .clk_i, .rst_ni, .head_i(head),
    .dq_rise_o, .dq_fall_o, .dq_oe_o, .dqs_en_o, .dqs_o
  );
endmodule

// File: rtl/ddr2_rd_seq_chk.sv
module ddr2_rd_seq_chk #(
  parameter int unsigned NB   = 8,
  parameter int unsigned BA_W = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cs_ni,
  input logic            ras_ni,
  input logic            cas_ni,
  input logic            we_ni,
  input logic [BA_W-1:0] ba_i,
  input logic            dq_oe_o,
  input logic            dqs_en_o,
  input logic            dqs_o,
  input logic [NB-1:0]   bank_open_o,
  input logic            rd_err_o
);
  logic rd_cmd, act_cmd;
  assign rd_cmd  = !cs_ni &&  ras_ni && !cas_ni && we_ni;
  assign act_cmd = !cs_ni && !ras_ni &&  cas_ni && we_ni;

  AST_DATA_STROBE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> dqs_en_o && dqs_o); // R6
  AST_PREAMBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> $past(dqs_en_o && !dqs_o)); // R5
  AST_POSTAMBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dq_oe_o) |-> dqs_en_o && !dqs_o); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |=> rd_err_o); // R10
  AST_CLOSED_READ_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cmd && !bank_open_o[ba_i] |=> rd_err_o); // R10

  for (genvar b = 0; b < NB; b++) begin : g_bank
    AST_OPEN_BY_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(bank_open_o[b]) |-> $past(act_cmd && ba_i == BA_W'(b))); // R1
  end
endmodule

bind ddr2_rd_seq ddr2_rd_seq_chk #(.NB(8), .BA_W(3)) i_chk (.*);

// File: tb/test_ddr2_rd_seq.sv
module test_ddr2_rd_seq;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1;
  logic [2:0] ba_i = '0;
  logic [10:0] addr_i = '0;
  logic mode_we_i = 1'b0, mode_sel_i = 1'b0;
  logic [6:0] mode_data_i = '0;
  logic [15:0] dq_rise_o, dq_fall_o;
  logic dq_oe_o, dqs_en_o, dqs_o, rd_err_o;
  logic [7:0] bank_open_o;

  ddr2_rd_seq i_ddr2_rd_seq (.*);

  always #2ns clk_i = ~clk_i;

  int tests = 0, fails = 0, cyc = 0, last_edge = 0;
  bit done = 0;

  // reference model state
  int m_cl = 3, m_al = 0;
  bit m_bl8 = 0, m_err = 0;
  bit [7:0] m_open = '0;
  int exp_kind [int];
  logic [15:0] exp_r [int], exp_f [int];
  logic [7:0] close_at [int];

  function automatic logic [15:0] word(int b, int c);
    return 16'((16*b + (c % 16)) * 753 + 315);
  endfunction

  function automatic int wrapc(int start, int e, bit bl8);
    int m = bl8 ? 7 : 3;
    return (start & ~m) | ((start + e) & m);
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at cyc %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      cyc = 0; m_cl = 3; m_al = 0; m_bl8 = 0; m_err = 0; m_open = '0;
      exp_kind.delete(); exp_r.delete(); exp_f.delete(); close_at.delete();
    end else begin
      int n, rl, h, b;
      cyc++;
      n = cyc;
      b = int'(ba_i);
      if (!cs_ni && ras_ni && !cas_ni && we_ni) begin
        if (m_open[b]) begin
          rl = m_al + m_cl;
          h = m_bl8 ? 4 : 2;
          if (!(exp_kind.exists(n+rl-1) && exp_kind[n+rl-1] == 2)) exp_kind[n+rl-1] = 1;
          for (int j = 0; j < h; j++) begin
            exp_kind[n+rl+j] = 2;
            exp_r[n+rl+j] = word(b, wrapc(int'(addr_i[9:0]), 2*j, m_bl8));
            exp_f[n+rl+j] = word(b, wrapc(int'(addr_i[9:0]), 2*j+1, m_bl8));
          end
          if (!exp_kind.exists(n+rl+h) || exp_kind[n+rl+h] == 0) exp_kind[n+rl+h] = 3;
          if (addr_i[10]) begin
            if (!close_at.exists(n+rl+h)) close_at[n+rl+h] = '0;
            close_at[n+rl+h][b] = 1'b1;
          end
        end else m_err = 1;
      end
      if (close_at.exists(n)) m_open &= ~close_at[n];
      if (!cs_ni && !ras_ni && cas_ni && we_ni) m_open[b] = 1'b1;
      if (mode_we_i) begin
        if (!mode_sel_i) begin
          if (mode_data_i[2:0] == 3'd2) m_bl8 = 0;
          else if (mode_data_i[2:0] == 3'd3) m_bl8 = 1;
          if (mode_data_i[6:4] >= 3 && mode_data_i[6:4] <= 6) m_cl = int'(mode_data_i[6:4]);
        end else if (mode_data_i[5:3] <= 5) m_al = int'(mode_data_i[5:3]);
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && cyc > 0) begin
      int k;
      string stag;
      logic [15:0] er, ef;
      k = exp_kind.exists(cyc) ? exp_kind[cyc] : 0;
      er = (k == 2) ? exp_r[cyc] : 16'h0;
      ef = (k == 2) ? exp_f[cyc] : 16'h0;
      stag = (k == 1) ? "R5" : (k == 2) ? "R6" : "R7";
      chk(dq_oe_o == (k == 2), "R3", "dq_oe", dq_oe_o, k == 2);
      chk(dq_rise_o == er && dq_fall_o == ef, "R4", "data",
          {dq_rise_o, dq_fall_o}, {er, ef});
      chk(dqs_en_o == (k != 0) && dqs_o == (k == 2), stag, "strobe",
          {dqs_en_o, dqs_o}, {k != 0, k == 2});
      chk(bank_open_o == m_open, "R9", "bank_open", bank_open_o, m_open);
      chk(rd_err_o == m_err, "R10", "rd_err", rd_err_o, m_err);
    end
  end

  task automatic nop(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic cmd(bit cs, bit ras, bit cas, bit we, int b, int a);
    @(negedge clk_i);
    {cs_ni, ras_ni, cas_ni, we_ni} = {cs, ras, cas, we};
    ba_i = 3'(b); addr_i = 11'(a);
    last_edge = cyc + 1;
    @(negedge clk_i);
    {cs_ni, ras_ni, cas_ni, we_ni} = 4'b1111;
  endtask

  task automatic act(int b);          cmd(0, 0, 1, 1, b, 0); endtask
  task automatic rd(int b, int c, bit ap); cmd(0, 1, 0, 1, b, {ap, 10'(c)}); endtask

  task automatic mode(bit sel, logic [6:0] v);
    @(negedge clk_i);
    mode_we_i = 1'b1; mode_sel_i = sel; mode_data_i = v;
    @(negedge clk_i);
    mode_we_i = 1'b0;
  endtask

  task automatic latency(int exp, string what);
    int issued = last_edge;
    while (!dq_oe_o) @(negedge clk_i);
    chk(cyc - issued == exp, "R2", what, cyc - issued, exp);
  endtask

  task automatic oe_run(int exp);
    int len = 0;
    while (!dq_oe_o) @(negedge clk_i);
    while (dq_oe_o) begin len++; @(negedge clk_i); end
    chk(len == exp, "R8", "chained oe run", len, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(dq_rise_o == 0 && dq_fall_o == 0 && !dq_oe_o && !dqs_en_o && !dqs_o
        && bank_open_o == 0 && !rd_err_o, "R11", "reset outputs",
        {dq_oe_o, dqs_en_o, dqs_o, rd_err_o, bank_open_o}, 0);
    rst_ni = 1'b1;
    nop(2);

    // default latency, odd start column wrap in BL4
    act(2);
    rd(2, 5, 0);
    latency(3, "default RL");
    nop(8);
    chk(bank_open_o[2] == 1'b1, "R9", "row kept open without ap", bank_open_o[2], 1);

    // ignored pin combinations
    cmd(1, 1, 0, 1, 3, 0);
    cmd(0, 0, 1, 0, 2, 11'h400);
    cmd(0, 1, 1, 1, 4, 0);
    nop(6);
    chk(bank_open_o == 8'h04 && !rd_err_o && !dqs_en_o, "R1", "ignored commands",
        {rd_err_o, dqs_en_o, bank_open_o}, 10'h004);

    // read to a closed bank
    rd(5, 0, 0);
    chk(rd_err_o == 1'b1, "R10", "error flag", rd_err_o, 1);
    nop(10);
    chk(!dqs_en_o && rd_err_o, "R10", "no activity, still flagged", {dqs_en_o, rd_err_o}, 1);

    // BL8, CL5, AL2, wrapping start column, auto-precharge
    mode(0, 7'h53);
    mode(1, 7'h10);
    rd(2, 13, 1);
    latency(7, "RL=AL+CL");
    nop(6);
    chk(bank_open_o[2] == 1'b0, "R9", "row closed by ap", bank_open_o[2], 0);

    // unsupported codes hold previous settings
    mode(0, 7'h75);
    mode(1, 7'h30);
    act(6);
    rd(6, 1020, 0);
    latency(7, "held after bad codes");
    nop(10);

    // BL4 CL4 AL0 chained at BL/2
    mode(0, 7'h42);
    mode(1, 7'h00);
    act(1);
    rd(1, 2, 0);
    rd(1, 7, 1);
    oe_run(4);
    chk(bank_open_o[1] == 1'b0, "R9", "closed after chained ap", bank_open_o[1], 0);
    nop(6);

    // one cycle gap: separate bursts
    act(1);
    rd(1, 0, 0);
    nop(1);
    rd(1, 9, 0);
    oe_run(2);
    nop(10);

    // worst latency BL8 CL6 AL5, three chained reads across banks
    mode(0, 7'h63);
    mode(1, 7'h28);
    act(3);
    act(4);
    rd(3, 1021, 0);
    nop(2);
    rd(4, 6, 1);
    nop(2);
    rd(3, 0, 0);
    oe_run(12);
    nop(20);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule